// File: doc/BRIEF.md
# LSB-Justified Stereo Audio Serial Port

This block is the master side of a stereo serial audio link. It generates a bit clock that idles low, a word-select line that marks the left and right channel slots, and one serial output line. It also samples one serial input line. The block moves data one half-word (16 bits) at a time. Software or a DMA engine writes half-words into a one-entry transmit stream and reads received half-words from a one-entry receive stream.

Three channel formats are supported:

- 16-bit data in a 16-bit slot.
- 32-bit data in a 32-bit slot.
- 24-bit data right-aligned in a 32-bit slot.

In the 24-bit format the first 8 bit times of each slot carry zeros, and the sample then follows MSB first, so the last bit of the slot is the sample's LSB. One 24-bit sample takes two half-word accesses. The first access carries sample bits 23..16 in its low byte, and the second carries bits 15..0. For example, sample 0x3478AE is written as 0x??34 and then 0x78AE, and it is read back as 0x0034 and then 0x78AE.

Both data streams use valid/ready handshakes. On the transmit side, `tx_ready` is high while the holding register is empty, and a beat transfers on a clock edge where both `tx_valid` and `tx_ready` are high. Back-pressure from the port is `tx_ready` staying low until the held half-word moves into the shifter at the start of the next half-word time. If the source does not supply data in time, zeros go out and a sticky underrun flag is set. On the receive side, `rx_valid` stays high and `rx_data` stays stable until the consumer raises `rx_ready`. The port cannot stall the wire, so a half-word that arrives while the previous one is still unread replaces it and sets a sticky overrun flag.

Top module: `lsbj_audio_port`

## Requirements
- R1: While `en` is low, `ck` is 0. After the first clock edge with `en` high, the first bit is launched CK_HALF clock edges later with `ck` low. From then on, `ck` alternates every CK_HALF edges: it rises halfway through each bit and falls as the next bit is launched.
- R2: `ws` is 0 during the left slot and 1 during the right slot, left first. It changes only as a bit is launched, never while `ck` is high. A slot is 16 bits for `fmt`=00 and 32 bits for `fmt`=01, 10 and 11.
- R3: In formats 00, 10 and 11, `sd_o` carries the written half-words MSB first and fills the slot. For a 32-bit slot, the first write supplies the upper half of the slot. `sd_o` changes only while `ck` is low.
- R4: In format 01, the first half-word of each slot goes out as 8 zeros followed by the low byte of the first write, MSB first. The upper byte of that write is ignored.
- R5: In format 01, the second half-word of each slot is the second write, bits 15..0, MSB first. Writes 0xAB34 and then 0x78AE therefore put the 32 bits 0x003478AE on the line.
- R6: The transmit holding register holds one half-word. `tx_ready` falls after an accepted beat and rises again on the edge that loads the held half-word into the shifter, which happens at the first bit of each half-word time.
- R7: If the holding register is empty at the start of a half-word time, 16 zero bits are sent and `underrun` is set. `underrun` stays set until `en` goes low.
- R8: `sd_i` is sampled on each rising edge of `ck`, MSB first. After the 16th bit of a half-word, that half-word appears on `rx_data` with `rx_valid` high. In format 01, the first half-word of each slot is delivered with bits 15..8 forced to 0. `rx_valid` stays high until a beat with `rx_ready` transfers.
- R9: If a half-word completes while the previous one is still unread, the new one replaces it and `overrun` is set. The flag is sticky until `en` goes low. A read on the same edge as the completion is not an overrun.
- R10: `tx_side` gives the channel (0 for left, 1 for right) of the half-word that the holding register will feed next. `rx_side` gives the channel of the half-word on `rx_data`.
- R11: When `en` is low, the port returns to its idle state on the next edge:
  - `ws` and `sd_o` are 0.
  - `tx_ready` is 1.
  - `rx_valid`, `underrun`, `overrun`, `tx_side` and `rx_side` are 0.
  - A new enable starts from the first bit of a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low returns the port to idle |
| fmt | input | 2 | Format: 00 = 16-bit slot, 01 = 24 bits in a 32-bit slot, 10 or 11 = 32-bit slot; change only while `en` is low |
| tx_data | input | 16 | Transmit half-word |
| tx_valid | input | 1 | Transmit beat offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_side | output | 1 | Channel of the next half-word the holding register feeds |
| rx_data | output | 16 | Received half-word |
| rx_valid | output | 1 | Received half-word pending |
| rx_ready | input | 1 | Consumer takes the pending half-word |
| rx_side | output | 1 | Channel of `rx_data` |
| underrun | output | 1 | Sticky: a half-word time started with no data |
| overrun | output | 1 | Sticky: unread receive data was replaced |
| ck | output | 1 | Serial bit clock, idles low |
| ws | output | 1 | Word select, 0 for left and 1 for right |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
The bench builds the port with CK_HALF = 2, so each bit lasts four system clocks. This is short enough for many complete frames of every format code to run, including stall windows that are long enough to cause underrun and overrun. The bench runs formats 00, 01, 10 and 11 in turn, each from a fresh enable. That exercises restarting on a left slot and covers all three slot layouts. Because the received patterns carry nonzero upper bytes, the masking of the 24-bit first half-word can be seen on the receive side.

// File: rtl/lsbj_pkg.sv
package lsbj_pkg;
  localparam int HW_W   = 16;               // half-word width
  localparam int BYTE_W = 8;                // zero-filled part of a 24-bit first half
  localparam int POS_W  = 6;                // bit position within a 64-bit frame
  localparam int HB_W   = $clog2(HW_W);     // bit index within a half-word

  typedef enum logic [1:0] {
    FMT_16  = 2'b00,
    FMT_24  = 2'b01,
    FMT_32  = 2'b10,
    FMT_32B = 2'b11
  } lsbj_fmt_e;

  // channel owning frame position p: 0 = left, 1 = right
  function automatic logic chan_of(input logic [POS_W-1:0] p, input logic [1:0] f);
    return (f == FMT_16) ? p[4] : p[5];
  endfunction

  // first half-word of a slot in the 24-bit format
  function automatic logic is_first24(input logic [POS_W-1:0] p, input logic [1:0] f);
    return (f == FMT_24) && !p[4];
  endfunction

  // last position of a frame
  function automatic logic [POS_W-1:0] frame_last(input logic [1:0] f);
    return (f == FMT_16) ? POS_W'(31) : POS_W'(63);
  endfunction
endpackage

// File: rtl/lsbj_tick_gen.sv
module lsbj_tick_gen #(
  parameter int CK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic launch,
  output logic capture
);
  localparam int CNT_W = $clog2(CK_HALF) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CK_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;   // 0: next tick launches, 1: next tick captures

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign launch  = en && (cnt_q == LAST) && !ph_q;
  assign capture = en && (cnt_q == LAST) &&  ph_q;
endmodule

// File: rtl/lsbj_tx_path.sv
module lsbj_tx_path
  import lsbj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       fmt,
  input  logic             launch,
  input  logic [HW_W-1:0]  tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_side,
  output logic             underrun,
  output logic             sd_o,
  output logic             ws,
  output logic [POS_W-1:0] lpos      // position of the bit on the line
);
  logic [POS_W-1:0] pos_q;           // next position to launch
  logic [HW_W-1:0]  hold_q, shreg_q, load_w;
  logic             full_q;
  logic             hw_start;
  logic [POS_W-1:0] ahead;

  assign hw_start = (pos_q[HB_W-1:0] == '0);
  assign ahead    = pos_q + POS_W'(HW_W);
  assign tx_ready = !full_q;

  always_comb begin
    load_w = full_q ? hold_q : '0;
    if (is_first24(pos_q, fmt)) load_w[HW_W-1:HW_W-BYTE_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0; lpos <= '0; hold_q <= '0; shreg_q <= '0; full_q <= 1'b0;
      sd_o <= 1'b0; ws <= 1'b0; tx_side <= 1'b0; underrun <= 1'b0;
    end else if (!en) begin
      pos_q <= '0; lpos <= '0; hold_q <= '0; shreg_q <= '0; full_q <= 1'b0;
      sd_o <= 1'b0; ws <= 1'b0; tx_side <= 1'b0; underrun <= 1'b0;
    end else begin
      if (launch) begin
        if (hw_start) begin
          sd_o    <= load_w[HW_W-1];
          shreg_q <= {load_w[HW_W-2:0], 1'b0};
          tx_side <= chan_of(ahead, fmt);
          if (full_q) full_q <= 1'b0;
          else        underrun <= 1'b1;
        end else begin
          sd_o    <= shreg_q[HW_W-1];
          shreg_q <= {shreg_q[HW_W-2:0], 1'b0};
        end
        ws    <= chan_of(pos_q, fmt);
        lpos  <= pos_q;
        pos_q <= (pos_q == frame_last(fmt)) ? '0 : pos_q + 1'b1;
      end
      if (tx_valid && !full_q) begin
        hold_q <= tx_data;
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsbj_rx_path.sv
module lsbj_rx_path
  import lsbj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       fmt,
  input  logic             capture,
  input  logic [POS_W-1:0] lpos,
  input  logic             sd_i,
  output logic [HW_W-1:0]  rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_side,
  output logic             overrun
);
  logic [HW_W-2:0] acc_q;
  logic [HW_W-1:0] word_w;
  logic            done_w;

  assign done_w = capture && (lpos[HB_W-1:0] == {HB_W{1'b1}});

  always_comb begin
    word_w = {acc_q, sd_i};
    if (is_first24(lpos, fmt)) word_w[HW_W-1:HW_W-BYTE_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; rx_data <= '0; rx_valid <= 1'b0; rx_side <= 1'b0; overrun <= 1'b0;
    end else if (!en) begin
      acc_q <= '0; rx_data <= '0; rx_valid <= 1'b0; rx_side <= 1'b0; overrun <= 1'b0;
    end else begin
      if (capture) acc_q <= {acc_q[HW_W-3:0], sd_i};
      if (done_w) begin
        rx_data  <= word_w;
        rx_side  <= chan_of(lpos, fmt);
        rx_valid <= 1'b1;
        if (rx_valid && !rx_ready) overrun <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsbj_audio_port.sv
module lsbj_audio_port
  import lsbj_pkg::*;
#(
  parameter int CK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  fmt,
  input  logic [15:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        tx_side,
  output logic [15:0] rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        rx_side,
  output logic        underrun,
  output logic        overrun,
  output logic        ck,
  output logic        ws,
  output logic        sd_o,
  input  logic        sd_i
);
  logic             launch, capture;
  logic [POS_W-1:0] lpos;

  lsbj_tick_gen #(.CK_HALF(CK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .launch(launch), .capture(capture)
  );

  lsbj_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .launch(launch),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_side(tx_side), .underrun(underrun), .sd_o(sd_o), .ws(ws), .lpos(lpos)
  );

  lsbj_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .capture(capture),
    .lpos(lpos), .sd_i(sd_i), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_side(rx_side), .overrun(overrun)
  );

  // bit clock: high from mid-bit capture to the next launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ck <= 1'b0;
    else if (!en)     ck <= 1'b0;
    else if (capture) ck <= 1'b1;
    else if (launch)  ck <= 1'b0;
  end
endmodule

// File: rtl/lsbj_audio_port_chk.sv
module lsbj_audio_port_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ck,
  input logic ws,
  input logic sd_o,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic underrun,
  input logic overrun
);
  // R2: word select moves only while the bit clock is low
  a_r2_ws_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> !ck);

  // R3: serial data moves only while the bit clock is low
  a_r3_sd_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_o) |-> !ck);

  // R6: an accepted beat fills the holding register
  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_valid && tx_ready) |=> !tx_ready);

  // R7: underrun is sticky while enabled
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && underrun) |=> underrun);

  // R8: pending receive data waits for the consumer
  a_r8_rx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_valid && !rx_ready) |=> rx_valid);

  // R9: overrun is sticky while enabled
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && overrun) |=> overrun);

  // R11: disabling returns the port to idle
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ck && !ws && !sd_o && tx_ready && !rx_valid && !underrun && !overrun));
endmodule

bind lsbj_audio_port lsbj_audio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ck(ck), .ws(ws), .sd_o(sd_o),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .underrun(underrun), .overrun(overrun)
);

// File: tb/lsbj_audio_port_bench.sv
`timescale 1ns/1ps
module lsbj_audio_port_bench;
  localparam int CK_HALF = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rst_n = 1'b0, en = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b0, sd_i = 1'b0;
  logic        tx_ready, tx_side, rx_valid, rx_side, underrun, overrun, ck, ws, sd_o;
  logic [15:0] rx_data;

  lsbj_audio_port #(.CK_HALF(CK_HALF)) u_lsbj_audio_port (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_side(tx_side),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_side(rx_side), .underrun(underrun), .overrun(overrun),
    .ck(ck), .ws(ws), .sd_o(sd_o), .sd_i(sd_i)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit tx_hold = 1, rx_hold = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] tx_gen(input int i);
    if (i == 0) return 16'hAB34;
    if (i == 1) return 16'h78AE;
    return 16'(i * 40503) ^ 16'h5A00;
  endfunction

  function automatic logic [15:0] rx_gen(input int i);
    return 16'hC3A5 ^ 16'(i * 7431);
  endfunction

  function automatic int fbits();  return (fmt == 2'b00) ? 32 : 64; endfunction
  function automatic bit chan(input int p);
    return (fmt == 2'b00) ? bit'((p / 16) % 2) : bit'((p / 32) % 2);
  endfunction
  function automatic bit first24(input int p); return (fmt == 2'b01) && ((p % 32) < 16); endfunction

  // behavioural reference model, advanced at each rising edge
  int m, lastp, tx_seq, rx_idx, capn;
  bit mfull, msd, mws, mck, mtxside, munder, mover, mrxv, mrxside, src_bit;
  logic [15:0] mbuf, mcur, mrxd, macc, rxw;
  logic [31:0] col;

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m = 0; lastp = 0; tx_seq = 0; rx_idx = 0; capn = 0; col = '0;
      mfull = 0; msd = 0; mws = 0; mck = 0; mtxside = 0; munder = 0; mover = 0;
      mrxv = 0; mrxside = 0; src_bit = 0; mbuf = '0; mcur = '0; mrxd = '0; macc = '0; rxw = '0;
    end else begin
      bit wr, rd;
      logic [15:0] wdata;
      wr = tx_valid && !mfull; rd = rx_ready && mrxv; wdata = tx_data;
      m++;
      if (m >= CK_HALF && (m - CK_HALF) % (2 * CK_HALF) == 0) begin
        int b, p;
        b = (m - CK_HALF) / (2 * CK_HALF); p = b % fbits();
        if (p % 16 == 0) begin
          logic [15:0] hw;
          if (mfull) begin hw = mbuf; mfull = 0; end
          else begin hw = '0; munder = 1; end
          if (first24(p)) hw[15:8] = 8'h00;
          mcur = hw; mtxside = chan((p + 16) % fbits());
          rxw = rx_gen(rx_idx); rx_idx++;
        end
        msd = mcur[15 - p % 16]; mws = chan(p); mck = 0; lastp = p;
        src_bit = rxw[15 - p % 16];
      end
      if (m >= 2 * CK_HALF && m % (2 * CK_HALF) == 0) begin
        mck = 1;
        if (fmt == 2'b01 && capn < 32) begin col = {col[30:0], sd_o}; capn++; end
        macc = {macc[14:0], src_bit};
        if (lastp % 16 == 15) begin
          logic [15:0] w;
          w = macc;
          if (first24(lastp)) w[15:8] = 8'h00;
          if (mrxv && !rd) mover = 1;
          mrxv = 1; mrxd = w; mrxside = chan(lastp);
        end else if (rd) mrxv = 0;
      end else if (rd) mrxv = 0;
      if (wr) begin mbuf = wdata; mfull = 1; tx_seq++; end
    end
  end

  // stimulus drivers, away from the active edge
  always @(negedge clk) begin
    tx_data  <= tx_gen(tx_seq);
    tx_valid <= !tx_hold;
    rx_ready <= !rx_hold;
    sd_i     <= src_bit;
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string t1, t2, t3, t6, t7, t8, t9, t10;
      t1 = en ? "R1" : "R11"; t2 = en ? "R2" : "R11";
      t3 = !en ? "R11" : (fmt == 2'b01 ? "R4" : "R3");
      t6 = en ? "R6" : "R11"; t7 = en ? "R7" : "R11"; t8 = en ? "R8" : "R11";
      t9 = en ? "R9" : "R11"; t10 = en ? "R10" : "R11";
      chk(ck == mck, t1, 32'(ck), 32'(mck));
      chk(ws == mws, t2, 32'(ws), 32'(mws));
      chk(sd_o == msd, t3, 32'(sd_o), 32'(msd));
      chk(tx_ready == !mfull, t6, 32'(tx_ready), 32'(!mfull));
      chk(underrun == munder, t7, 32'(underrun), 32'(munder));
      chk(rx_valid == mrxv, t8, 32'(rx_valid), 32'(mrxv));
      if (mrxv) chk(rx_data == mrxd, t8, 32'(rx_data), 32'(mrxd));
      chk(overrun == mover, t9, 32'(overrun), 32'(mover));
      chk(tx_side == mtxside, t10, 32'(tx_side), 32'(mtxside));
      chk(rx_side == mrxside, t10, 32'(rx_side), 32'(mrxside));
    end
  end

  task automatic run_phase(input logic [1:0] f);
    @(negedge clk);
    fmt = f; tx_hold = 0; rx_hold = 0;
    @(negedge clk);
    en = 1;
    repeat (900) @(negedge clk);
    if (f == 2'b01) begin
      chk(col[31:16] == 16'h0034, "R4", col, 32'h003478AE);
      chk(col[15:0]  == 16'h78AE, "R5", col, 32'h003478AE);
    end
    tx_hold = 1; repeat (200) @(negedge clk);
    chk(underrun == 1'b1, "R7", 32'(underrun), 32'd1);
    tx_hold = 0; repeat (300) @(negedge clk);
    rx_hold = 1; repeat (250) @(negedge clk);
    chk(overrun == 1'b1, "R9", 32'(overrun), 32'd1);
    rx_hold = 0; repeat (300) @(negedge clk);
    en = 0;
    repeat (4) @(negedge clk);
    chk(!underrun && !overrun && tx_ready && !ck && !ws, "R11",
        {27'd0, underrun, overrun, tx_ready, ck, ws}, 32'h4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(tx_ready == 1'b1 && !rx_valid && !ck && !ws && !sd_o, "R11",
        {27'd0, tx_ready, rx_valid, ck, ws, sd_o}, 32'h10);
    run_phase(2'b00);
    run_phase(2'b01);
    run_phase(2'b10);
    run_phase(2'b11);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule